// File: doc/BRIEF.md
# Metering pulse output spacer

The block sits between an energy computation engine and a metering pulse pin. The engine raises a one-cycle request for each energy quantum. In queued mode the block counts pending requests and releases them as pulses, each starting one slot after the one before. The slot lasts four times the interval setting, counted in clock cycles. In pass-through mode, selected by an interval setting of zero, each request flips the pin straight away, so the output runs at 50% duty with one full period for every two requests.

In queued mode the active width of each pulse depends on the width setting. The all-ones code gives half of the spacing slot. Any other code gives (2*width+1) times the interval. If that width is longer than the slot, the next pulse waits until the active phase ends. The pin idles high and pulses low unless inversion is selected. The mode, the polarity and the width are latched only at a pulse boundary. Requests that find the queue full are dropped and counted on a saturating counter.

Top module: `pulse_spacer`

## Requirements
- R1: While rst_ni is low and just after it is released, pulse_o is 1 (inactive for the default active-low polarity), drop_cnt_o is 0 and no request is pending, so no pulse appears until a request arrives.
- R2: With interval_i = 0 (pass-through), each cycle with req_i = 1 toggles the active state, and the change is visible on pulse_o after the next rising edge. No request is queued in this mode.
- R3: With interval_i = N > 0, a request sampled at edge k starts a pulse at edge k+1. Further queued pulses start one slot after the previous start, where the slot is max(4*N, active width) cycles.
- R4: With maxwidth_i = 255, each queued pulse is active for 2*N cycles within its 4*N-cycle slot (50% duty).
- R5: With maxwidth_i = M < 255, each queued pulse is active for (2*M+1)*N cycles.
- R6: When (2*M+1)*N exceeds 4*N, the next queued pulse starts only after the active phase has ended, so consecutive starts are (2*M+1)*N cycles apart.
- R7: With invert_i = 1, pulse_o is active high and idles low. With invert_i = 0, it is active low and idles high.
- R8: The queue holds DEPTH (default 8) pending requests. A request that arrives when the queue is full and nothing is released in that cycle is dropped, and drop_cnt_o increments, saturating at 255.
- R9: The settings interval_i, maxwidth_i and invert_i are latched only at a pulse boundary, meaning an idle cycle or the last cycle of a slot. Changes made during a pulse alter neither its width nor its polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all timing is counted in its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One-cycle pulse request from the computation engine |
| interval_i | input | 8 | Interval setting N; 0 selects pass-through |
| maxwidth_i | input | 8 | Width setting M; 255 selects 50% duty |
| invert_i | input | 1 | 1 selects an active-high output |
| pulse_o | output | 1 | Pulse pin |
| drop_cnt_o | output | 8 | Saturating count of requests dropped on a full queue |

## Verification
The bench uses the defaults: 8-bit settings, a queue depth of 8 and an 8-bit drop counter. The depth of 8 lets a burst of twelve back-to-back requests at a long interval fill the queue and produce exactly three drops. The 8-bit counter lets a burst of a few hundred requests drive it into saturation. Random runs keep the interval small, from 1 to 6. Width codes range over 0 to 3 and the 50% code, so slot-bound and width-bound spacing both occur within a few hundred cycles per run.

// File: rtl/pulse_spacer_pkg.sv
package pulse_spacer_pkg;

  typedef struct packed {
    logic busy;
    logic active;
    logic last;
  } slot_stat_t;

  // active cycles for one queued pulse
  function automatic int unsigned act_cycles(int unsigned iv, int unsigned mw,
                                             int unsigned mw_full);
    return (mw == mw_full) ? 2 * iv : (2 * mw + 1) * iv;
  endfunction

  function automatic int unsigned slot_cycles(int unsigned iv, int unsigned act);
    return (act > 4 * iv) ? act : 4 * iv;
  endfunction

endpackage

// File: rtl/pulse_pend_ctr.sv
module pulse_pend_ctr #(
  parameter int DEPTH  = 8,
  parameter int DROP_W = 8,
  parameter int PW     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  output logic              nz_o,
  output logic [PW-1:0]     cnt_o,
  output logic [DROP_W-1:0] drop_o
);
  localparam logic [PW-1:0]     FULL_CNT = PW'(DEPTH);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic [PW-1:0]     cnt_q;
  logic [DROP_W-1:0] drop_q;
  logic              full, accept, drop;

  always_comb begin
    full   = (cnt_q == FULL_CNT);
    accept = push_i && (!full || pop_i);
    drop   = push_i && full && !pop_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      drop_q <= '0;
    end else begin
      if (accept && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (!accept && pop_i) cnt_q <= cnt_q - 1'b1;
      if (drop && drop_q != DROP_MAX) drop_q <= drop_q + 1'b1;
    end
  end

  assign nz_o   = (cnt_q != '0);
  assign cnt_o  = cnt_q;
  assign drop_o = drop_q;
endmodule

// File: rtl/pulse_slot_timer.sv
module pulse_slot_timer
  import pulse_spacer_pkg::*;
#(
  parameter int TW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] act_len_i,
  input  logic [TW-1:0] slot_len_i,
  output slot_stat_t    stat_o
);
  logic          busy_q;
  logic [TW-1:0] t_q, act_q, slot_q;
  logic          last;

  assign last = busy_q && (t_q == slot_q - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      t_q    <= '0;
      act_q  <= '0;
      slot_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      t_q    <= '0;
      act_q  <= act_len_i;
      slot_q <= slot_len_i;
    end else if (last) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      t_q <= t_q + 1'b1;
    end
  end

  assign stat_o.busy   = busy_q;
  assign stat_o.active = busy_q && (t_q < act_q);
  assign stat_o.last   = last;
endmodule

// File: rtl/pulse_spacer.sv
module pulse_spacer
  import pulse_spacer_pkg::*;
#(
  parameter int SET_W  = 8,
  parameter int DEPTH  = 8,
  parameter int DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [SET_W-1:0]  interval_i,
  input  logic [SET_W-1:0]  maxwidth_i,
  input  logic              invert_i,
  output logic              pulse_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam int              TW      = 2 * SET_W + 1;
  localparam int              PW      = $clog2(DEPTH + 1);
  localparam logic [SET_W-1:0] MW_FULL = '1;

  logic          bypass_q, inv_q, tog_q;
  logic          pend_nz, slot_busy;
  logic [PW-1:0] pend_cnt;
  logic          boundary, start, push, active;
  logic [TW-1:0] act_len, slot_len;
  int unsigned   act_u, slot_u;
  slot_stat_t    st;

  always_comb begin
    // settings may change only between pulses
    boundary = st.busy ? st.last : (!tog_q && !(bypass_q && req_i));
    start    = boundary && (interval_i != '0) && pend_nz;
    push     = !bypass_q && req_i;
    act_u    = act_cycles(32'(interval_i), 32'(maxwidth_i), 32'(MW_FULL));
    slot_u   = slot_cycles(32'(interval_i), act_u);
    act_len  = TW'(act_u);
    slot_len = TW'(slot_u);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_q <= 1'b1;
      inv_q    <= 1'b0;
    end else if (boundary) begin
      bypass_q <= (interval_i == '0);
      inv_q    <= invert_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tog_q <= 1'b0;
    else if (bypass_q && req_i) tog_q <= ~tog_q;
  end

  pulse_pend_ctr #(
    .DEPTH (DEPTH),
    .DROP_W(DROP_W),
    .PW    (PW)
  ) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(push),
    .pop_i (start),
    .nz_o  (pend_nz),
    .cnt_o (pend_cnt),
    .drop_o(drop_cnt_o)
  );

  pulse_slot_timer #(
    .TW(TW)
  ) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .act_len_i (act_len),
    .slot_len_i(slot_len),
    .stat_o    (st)
  );

  assign slot_busy = st.busy;
  assign active    = st.busy ? st.active : tog_q;
  assign pulse_o   = inv_q ? active : ~active;
endmodule

// File: rtl/pulse_spacer_chk.sv
module pulse_spacer_chk #(
  parameter int DEPTH  = 8,
  parameter int DROP_W = 8,
  parameter int PW     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              pulse_o,
  input logic [DROP_W-1:0] drop_cnt_o,
  input logic [PW-1:0]     pend_cnt,
  input logic              slot_busy,
  input logic              bypass_q
);
  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_reset_idle : assert (pulse_o === 1'b1 && drop_cnt_o == '0);
  end

  a_r8_pend_bound : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_cnt <= PW'(DEPTH));

  a_r8_drop_only_on_req : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(drop_cnt_o));

  a_r8_drop_monotonic : assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> drop_cnt_o >= $past(drop_cnt_o));

  a_r3_start_needs_pending : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slot_busy) |-> $past(pend_cnt) != '0);

  a_r2_bypass_no_queue : assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_q && req_i |=> pend_cnt <= $past(pend_cnt));
endmodule

bind pulse_spacer pulse_spacer_chk #(
  .DEPTH (DEPTH),
  .DROP_W(DROP_W),
  .PW    (PW)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .pulse_o   (pulse_o),
  .drop_cnt_o(drop_cnt_o),
  .pend_cnt  (pend_cnt),
  .slot_busy (slot_busy),
  .bypass_q  (bypass_q)
);

// File: tb/sim_pulse_spacer.sv
module sim_pulse_spacer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       req = 1'b0;
  logic       inv = 1'b0;
  logic [7:0] iv = 8'd0;
  logic [7:0] mw = 8'hFF;
  logic       pulse;
  logic [7:0] drop;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pulse_spacer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .interval_i(iv),
    .maxwidth_i(mw), .invert_i(inv), .pulse_o(pulse), .drop_cnt_o(drop)
  );

  task automatic chk(bit ok, string tag, int got, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int f_act(int v, int m);
    return (m == 255) ? 2 * v : (2 * m + 1) * v;
  endfunction

  function automatic int f_slot(int v, int m);
    int a = f_act(v, m);
    return (a > 4 * v) ? a : 4 * v;
  endfunction

  function automatic bit f_lvl(bit a, bit p);
    return p ? a : !a;
  endfunction

  function automatic bit f_exp(int rel, int n, int a, int s);
    if (rel < 1) return 1'b0;
    return ((rel - 1) / s < n) && ((rel - 1) % s < a);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic queued_run(int v, int m, bit p, int n, string tag);
    int a = f_act(v, m);
    int s = f_slot(v, m);
    int bad_rel = -1;
    int got = 0;
    int ex = 0;
    iv = 8'(v); mw = 8'(m); inv = p;
    repeat (3) @(negedge clk);
    req = 1'b1;
    for (int rel = 0; rel < n * s + 6; rel++) begin
      @(negedge clk);
      req = (rel + 1 < n);
      if (bad_rel < 0 && pulse !== f_lvl(f_exp(rel, n, a, s), p)) begin
        bad_rel = rel; got = pulse; ex = f_lvl(f_exp(rel, n, a, s), p);
      end
    end
    if (bad_rel >= 0) $display("  at cycle %0d of iv=%0d mw=%0d n=%0d", bad_rel, v, m, n);
    chk(bad_rel < 0, tag, got, ex);
  endtask

  task automatic bypass_run(bit p);
    bit t = 1'b0;
    bit ok;
    iv = 8'd0; inv = p;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      int gap = 1 + int'($urandom_range(3));
      ok = 1'b1;
      repeat (gap) begin
        @(negedge clk);
        if (pulse !== f_lvl(t, p)) ok = 1'b0;
      end
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      t = ~t;
      chk(ok && pulse === f_lvl(t, p), p ? "R2 R7 bypass toggle" : "R2 bypass toggle",
          pulse, f_lvl(t, p));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk(pulse === 1'b1 && drop == 8'd0, "R1 in reset", pulse, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(pulse === 1'b1 && drop == 8'd0, "R1 after reset", pulse, 1);

    // R1: nothing pending, queued mode shows no pulse
    iv = 8'd3;
    begin
      bit ok = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (pulse !== 1'b1) ok = 1'b0;
      end
      chk(ok, "R1 empty queue idle", pulse, 1);
    end

    bypass_run(1'b0);
    bypass_run(1'b1);

    queued_run(2, 255, 1'b0, 3, "R3 R4 half duty");
    queued_run(3, 0, 1'b1, 2, "R5 R7 min width inverted");
    queued_run(2, 5, 1'b0, 2, "R6 width bound spacing");
    queued_run(1, 1, 1'b0, 4, "R3 R5 width equals 3");

    for (int r = 0; r < 8; r++) begin
      int v = 1 + int'($urandom_range(5));
      int m = ($urandom_range(1) == 0) ? 255 : int'($urandom_range(3));
      bit p = 1'($urandom_range(1));
      int n = 1 + int'($urandom_range(3));
      string tag;
      if (m == 255)              tag = "R3 R4 random";
      else if (f_act(v, m) > 4*v) tag = "R3 R6 random";
      else                       tag = "R3 R5 random";
      queued_run(v, m, p, n, tag);
    end
    inv = 1'b0;
    repeat (3) @(negedge clk);

    // R9: settings changed mid-pulse are held off until the boundary
    iv = 8'd4; mw = 8'hFF; inv = 1'b0;
    repeat (3) @(negedge clk);
    req = 1'b1;
    begin
      bit ok_a = 1'b1, ok_b = 1'b1, ok_c = 1'b1;
      for (int rel = 0; rel < 25; rel++) begin
        @(negedge clk);
        req = 1'b0;
        if (rel == 2) begin mw = 8'd0; inv = 1'b1; end
        if (rel >= 1 && rel <= 8 && pulse !== 1'b0) ok_a = 1'b0;
        if (rel >= 9 && rel <= 16 && pulse !== 1'b1) ok_b = 1'b0;
        if (rel >= 18 && pulse !== 1'b0) ok_c = 1'b0;
      end
      chk(ok_a, "R9 width kept during pulse", pulse, 0);
      chk(ok_b, "R9 polarity kept in slot", pulse, 1);
      chk(ok_c, "R7 R9 new polarity after boundary", pulse, 0);
    end
    inv = 1'b0; mw = 8'hFF;

    // R8: queue fills, three drops
    do_reset();
    iv = 8'd50;
    repeat (3) @(negedge clk);
    req = 1'b1;
    repeat (12) @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk(drop == 8'd3, "R8 drops on full queue", drop, 3);

    // R8: saturation
    do_reset();
    chk(drop == 8'd0, "R1 drop count cleared", drop, 0);
    iv = 8'd50;
    repeat (3) @(negedge clk);
    req = 1'b1;
    repeat (300) @(negedge clk);
    req = 1'b0;
    repeat (2) @(negedge clk);
    chk(drop == 8'd255, "R8 drop count saturates", drop, 255);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule